// File: doc/BRIEF.md
# Clock Tree Frequency Evaluator

This block works out, on request, the frequency in hertz of one clock root of a fixed clock tree, given the current settings of that tree's control fields. The tree has a crystal reference, a system PLL with two multiplier settings, two fractional dividers driven from that PLL, and a four-way source selector. After the selector come three integer post-dividers in series: a bus stage, an IPG stage and a peripheral-timer stage. Software or a timer model raises `start` with a clock identifier and the field values. The block then walks the tree with one shared iterative shift-add multiplier and one shared iterative restoring divider. It returns a 32-bit frequency together with a one-cycle `done` pulse.

The result uses floor arithmetic at each stage, in the order the tree is built. It does not generate a clock. Identifiers that need no arithmetic (off, slow oscillator, crystal, crystal divided by eight, unsupported) are answered without running the datapath. Any selected fractional divider with a zero fraction is reported through an error flag and gives a zero result, so no division by zero takes place.

Top module: `clkfreq_eval`

## Requirements
- R1: After reset, `done` is 0, `freq_hz` is 0 and `err` is 0.
- R2: Identifier encoding on `clk_id`: 0 = off, giving 0; 3 = slow oscillator, giving 32768; 4 = crystal, giving 24000000; 5 = crystal divided by eight, giving 3000000; 6 and 7 are unsupported and give 0. All of these give `err` = 0.
- R3: For identifier 1 (IPG) with `root_sel` = 0, the source is the system PLL. The PLL is 24000000 × 22 when `pll_hi` = 1 and 24000000 × 20 when `pll_hi` = 0.
- R4: With `root_sel` = 1 the source is floor(PLL × 18 / `frac_b`). With `root_sel` = 2 the source is floor(PLL × 18 / `frac_a`).
- R5: With `root_sel` = 3 the source is floor(floor(PLL × 18 / `frac_b`) / 2).
- R6: The IPG result is floor(floor(source / (1 + `bus_div`)) / (1 + `ipg_div`)). `bus_div` is 3 bits and `ipg_div` is 2 bits.
- R7: For identifier 2 (peripheral timer), the IPG result is further divided, with floor, by (1 + `tmr_div`), where `tmr_div` is 6 bits.
- R8: If `root_sel` is 1, 2 or 3 and the fraction it selects is 0, the result is 0 with `err` = 1. A zero fraction that `root_sel` does not select has no effect.
- R9: `done` is high for exactly one cycle per accepted request. `freq_hz` and `err` change only when `done` is high, and they hold until the next `done`.
- R10: Field values and the identifier are captured when `start` is accepted. A `start` or an input change while a request is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, accepted when idle |
| clk_id | input | 3 | Clock identifier to evaluate |
| pll_hi | input | 1 | PLL multiplier select (1: ×22, 0: ×20) |
| frac_a | input | 6 | Fraction of fractional output A |
| frac_b | input | 6 | Fraction of fractional output B |
| root_sel | input | 2 | Source selector before the post-dividers |
| bus_div | input | 3 | Bus stage divider minus one |
| ipg_div | input | 2 | IPG stage divider minus one |
| tmr_div | input | 6 | Peripheral-timer stage divider minus one |
| done | output | 1 | One-cycle result-valid pulse |
| freq_hz | output | 32 | Computed frequency in Hz |
| err | output | 1 | Zero-fraction error, valid with done |

## Verification
The assertions watch, on every cycle, the properties that hold whatever the input values are. `done` never lasts two cycles. `freq_hz` and `err` move only together with `done`. An error result always carries a zero frequency. The divider always starts with a nonzero divisor and always finishes with a remainder below that divisor. Only the bench scenarios can show that the numbers are correct: the PLL multiplier choice, the selection and floor behaviour of each source, the order of the post-divider stages, the decoding of the identifiers, and that a start arriving mid-computation changes nothing.

// File: rtl/clkfreq_pkg.sv
package clkfreq_pkg;
   localparam logic [2:0] CID_OFF     = 3'd0;
   localparam logic [2:0] CID_IPG     = 3'd1;
   localparam logic [2:0] CID_TIMER   = 3'd2;
   localparam logic [2:0] CID_SLOW    = 3'd3;
   localparam logic [2:0] CID_XTAL    = 3'd4;
   localparam logic [2:0] CID_XTAL_D8 = 3'd5;

   typedef enum logic [2:0] {
      ST_IDLE, ST_PLL, ST_FMUL, ST_FDIV, ST_BUS, ST_IPG, ST_TMR, ST_FIN
   } walk_state_t;
endpackage

// File: rtl/clkfreq_mul.sv
module clkfreq_mul #(
   parameter int A_W = 64,
   parameter int B_W = 5
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           go,
   input  logic [A_W-1:0] a,
   input  logic [B_W-1:0] b,
   output logic           done,
   output logic [A_W-1:0] prod
);
   localparam int CW = $clog2(B_W + 1);

   logic [A_W-1:0] acc, sh_a;
   logic [B_W-1:0] sh_b;
   logic [CW-1:0]  cnt;
   logic           busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc  <= '0;
         sh_a <= '0;
         sh_b <= '0;
         cnt  <= '0;
         busy <= 1'b0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (go && !busy) begin
            acc  <= '0;
            sh_a <= a;
            sh_b <= b;
            cnt  <= CW'(B_W);
            busy <= 1'b1;
         end else if (busy) begin
            if (sh_b[0]) acc <= acc + sh_a;
            sh_a <= sh_a << 1;
            sh_b <= sh_b >> 1;
            cnt  <= cnt - 1'b1;
            if (cnt == CW'(1)) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end

   assign prod = acc;
endmodule

// File: rtl/clkfreq_div.sv
module clkfreq_div #(
   parameter int N_W = 64,
   parameter int D_W = 7
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           go,
   input  logic [N_W-1:0] num,
   input  logic [D_W-1:0] den,
   output logic           done,
   output logic [N_W-1:0] quo
);
   localparam int CW = $clog2(N_W + 1);

   logic [D_W-1:0] rem, dvs;
   logic [CW-1:0]  cnt;
   logic           busy;
   logic [D_W:0]   trial;
   logic           ge;

   always_comb begin
      trial = {rem, quo[N_W-1]};
      ge    = (trial >= {1'b0, dvs});
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem  <= '0;
         dvs  <= '0;
         quo  <= '0;
         cnt  <= '0;
         busy <= 1'b0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (go && !busy) begin
            rem  <= '0;
            dvs  <= den;
            quo  <= num;
            cnt  <= CW'(N_W);
            busy <= 1'b1;
         end else if (busy) begin
            rem  <= ge ? D_W'(trial - {1'b0, dvs}) : trial[D_W-1:0];
            quo  <= {quo[N_W-2:0], ge};
            cnt  <= cnt - 1'b1;
            if (cnt == CW'(1)) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end

   // R8
   nonzero_divisor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (dvs != '0));

   // R6
   rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (rem < dvs));
endmodule

// File: rtl/clkfreq_eval.sv
module clkfreq_eval
   import clkfreq_pkg::*;
#(
   parameter int REF_HZ   = 24000000,
   parameter int SLOW_HZ  = 32768,
   parameter int XTAL_DV  = 8,
   parameter int PLL_LO   = 20,
   parameter int PLL_HI   = 22,
   parameter int FRAC_NUM = 18,
   parameter int FRAC_W   = 6,
   parameter int BUS_W    = 3,
   parameter int IPG_W    = 2,
   parameter int TMR_W    = 6,
   parameter int ACC_W    = 64,
   parameter int OUT_W    = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [2:0]        clk_id,
   input  logic              pll_hi,
   input  logic [FRAC_W-1:0] frac_a,
   input  logic [FRAC_W-1:0] frac_b,
   input  logic [1:0]        root_sel,
   input  logic [BUS_W-1:0]  bus_div,
   input  logic [IPG_W-1:0]  ipg_div,
   input  logic [TMR_W-1:0]  tmr_div,
   output logic              done,
   output logic [OUT_W-1:0]  freq_hz,
   output logic              err
);
   localparam int M1     = (PLL_LO > PLL_HI) ? PLL_LO : PLL_HI;
   localparam int MUL_MX = (M1 > FRAC_NUM) ? M1 : FRAC_NUM;
   localparam int MUL_W  = $clog2(MUL_MX + 1);
   localparam int W1     = (FRAC_W > BUS_W) ? FRAC_W : BUS_W;
   localparam int W2     = (IPG_W > TMR_W) ? IPG_W : TMR_W;
   localparam int DIV_W  = ((W1 > W2) ? W1 : W2) + 1;

   generate
      if (OUT_W > ACC_W) begin : g_bad_out
         $error("OUT_W must not exceed ACC_W");
      end
      if (XTAL_DV < 1) begin : g_bad_xdv
         $error("XTAL_DV must be at least 1");
      end
      if (ACC_W < 2) begin : g_bad_acc
         $error("ACC_W too small");
      end
   endgenerate

   walk_state_t       state;
   logic              issued;
   logic [2:0]        id_q;
   logic [1:0]        root_q;
   logic              hi_q;
   logic [FRAC_W-1:0] frac_q;
   logic [BUS_W-1:0]  bus_q;
   logic [IPG_W-1:0]  ipg_q;
   logic [TMR_W-1:0]  tmr_q;
   logic [ACC_W-1:0]  acc;
   logic              err_q;

   logic              mul_go, mul_done, div_go, div_done;
   logic [ACC_W-1:0]  mul_a, mul_p, div_q;
   logic [MUL_W-1:0]  mul_b;
   logic [DIV_W-1:0]  div_d;
   logic [FRAC_W-1:0] frac_pick;

   assign frac_pick = (root_sel == 2'd2) ? frac_a : frac_b;

   always_comb begin
      mul_go = 1'b0;
      mul_a  = ACC_W'(REF_HZ);
      mul_b  = '0;
      div_go = 1'b0;
      div_d  = DIV_W'(1);
      unique case (state)
         ST_PLL: begin
            mul_go = !issued;
            mul_b  = hi_q ? MUL_W'(PLL_HI) : MUL_W'(PLL_LO);
         end
         ST_FMUL: begin
            mul_go = !issued;
            mul_a  = acc;
            mul_b  = MUL_W'(FRAC_NUM);
         end
         ST_FDIV: begin
            div_go = !issued;
            div_d  = DIV_W'(frac_q);
         end
         ST_BUS: begin
            div_go = !issued;
            div_d  = DIV_W'(bus_q) + DIV_W'(1);
         end
         ST_IPG: begin
            div_go = !issued;
            div_d  = DIV_W'(ipg_q) + DIV_W'(1);
         end
         ST_TMR: begin
            div_go = !issued;
            div_d  = DIV_W'(tmr_q) + DIV_W'(1);
         end
         default: ;
      endcase
   end

   clkfreq_mul #(.A_W(ACC_W), .B_W(MUL_W)) u_mul (
      .clk(clk), .rst_n(rst_n), .go(mul_go), .a(mul_a), .b(mul_b),
      .done(mul_done), .prod(mul_p)
   );

   clkfreq_div #(.N_W(ACC_W), .D_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .go(div_go), .num(acc), .den(div_d),
      .done(div_done), .quo(div_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         issued  <= 1'b0;
         id_q    <= '0;
         root_q  <= '0;
         hi_q    <= 1'b0;
         frac_q  <= '0;
         bus_q   <= '0;
         ipg_q   <= '0;
         tmr_q   <= '0;
         acc     <= '0;
         err_q   <= 1'b0;
         done    <= 1'b0;
         freq_hz <= '0;
         err     <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: if (start) begin
               id_q   <= clk_id;
               root_q <= root_sel;
               hi_q   <= pll_hi;
               frac_q <= frac_pick;
               bus_q  <= bus_div;
               ipg_q  <= ipg_div;
               tmr_q  <= tmr_div;
               issued <= 1'b0;
               err_q  <= 1'b0;
               acc    <= '0;
               state  <= ST_FIN;
               unique case (clk_id)
                  CID_IPG, CID_TIMER: begin
                     if (root_sel != 2'd0 && frac_pick == '0) err_q <= 1'b1;
                     else state <= ST_PLL;
                  end
                  CID_SLOW:    acc <= ACC_W'(SLOW_HZ);
                  CID_XTAL:    acc <= ACC_W'(REF_HZ);
                  CID_XTAL_D8: acc <= ACC_W'(REF_HZ / XTAL_DV);
                  default:     acc <= '0;
               endcase
            end
            ST_PLL: if (!issued) issued <= 1'b1;
               else if (mul_done) begin
                  issued <= 1'b0;
                  acc    <= mul_p;
                  state  <= (root_q == 2'd0) ? ST_BUS : ST_FMUL;
               end
            ST_FMUL: if (!issued) issued <= 1'b1;
               else if (mul_done) begin
                  issued <= 1'b0;
                  acc    <= mul_p;
                  state  <= ST_FDIV;
               end
            ST_FDIV: if (!issued) issued <= 1'b1;
               else if (div_done) begin
                  issued <= 1'b0;
                  acc    <= (root_q == 2'd3) ? (div_q >> 1) : div_q;
                  state  <= ST_BUS;
               end
            ST_BUS: if (!issued) issued <= 1'b1;
               else if (div_done) begin
                  issued <= 1'b0;
                  acc    <= div_q;
                  state  <= ST_IPG;
               end
            ST_IPG: if (!issued) issued <= 1'b1;
               else if (div_done) begin
                  issued <= 1'b0;
                  acc    <= div_q;
                  state  <= (id_q == CID_TIMER) ? ST_TMR : ST_FIN;
               end
            ST_TMR: if (!issued) issued <= 1'b1;
               else if (div_done) begin
                  issued <= 1'b0;
                  acc    <= div_q;
                  state  <= ST_FIN;
               end
            ST_FIN: begin
               freq_hz <= acc[OUT_W-1:0];
               err     <= err_q;
               done    <= 1'b1;
               state   <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9
   freq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(freq_hz) |-> done);

   // R9
   err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(err) |-> done);

   // R8
   err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (freq_hz == '0));
endmodule

// File: tb/clkfreq_eval_tb.sv
module clkfreq_eval_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  clk_id = '0;
   logic        pll_hi = 1'b0;
   logic [5:0]  frac_a = '0, frac_b = '0;
   logic [1:0]  root_sel = '0;
   logic [2:0]  bus_div = '0;
   logic [1:0]  ipg_div = '0;
   logic [5:0]  tmr_div = '0;
   logic        done;
   logic [31:0] freq_hz;
   logic        err;

   int n_chk = 0;
   int n_err = 0;

   always #5 clk = ~clk;

   clkfreq_eval u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .clk_id(clk_id),
      .pll_hi(pll_hi), .frac_a(frac_a), .frac_b(frac_b),
      .root_sel(root_sel), .bus_div(bus_div), .ipg_div(ipg_div),
      .tmr_div(tmr_div), .done(done), .freq_hz(freq_hz), .err(err)
   );

   task automatic check(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic void model(input logic [2:0] id, input logic hi,
         input logic [5:0] fa, input logic [5:0] fb, input logic [1:0] rs,
         input logic [2:0] bd, input logic [1:0] id2, input logic [5:0] td,
         output longint f, output bit e);
      longint unsigned pll, src;
      logic [5:0] fr;
      e = 0;
      f = 0;
      case (id)
         3'd3: f = 32768;
         3'd4: f = 24000000;
         3'd5: f = 3000000;
         3'd1, 3'd2: begin
            pll = 64'd24000000 * (hi ? 64'd22 : 64'd20);
            fr  = (rs == 2'd2) ? fa : fb;
            if (rs != 0 && fr == 0) begin
               e = 1;
            end else begin
               if (rs == 0) src = pll;
               else src = (pll * 18) / fr;
               if (rs == 3) src = src / 2;
               src = src / (bd + 1);
               src = src / (id2 + 1);
               if (id == 3'd2) src = src / (td + 1);
               f = longint'(src[31:0]);
            end
         end
         default: f = 0;
      endcase
   endfunction

   task automatic drive(input logic [2:0] id, input logic hi, input logic [5:0] fa,
         input logic [5:0] fb, input logic [1:0] rs, input logic [2:0] bd,
         input logic [1:0] id2, input logic [5:0] td);
      clk_id = id; pll_hi = hi; frac_a = fa; frac_b = fb;
      root_sel = rs; bus_div = bd; ipg_div = id2; tmr_div = td;
   endtask

   task automatic wait_done(input string req, output bit ok);
      ok = 0;
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         if (done) begin ok = 1; break; end
      end
      if (!ok) check({req, " done timeout"}, 0, 1);
   endtask

   task automatic run(input string req, input logic [2:0] id, input logic hi,
         input logic [5:0] fa, input logic [5:0] fb, input logic [1:0] rs,
         input logic [2:0] bd, input logic [1:0] id2, input logic [5:0] td);
      longint f; bit e; bit ok;
      logic [31:0] held;
      model(id, hi, fa, fb, rs, bd, id2, td, f, e);
      @(negedge clk);
      drive(id, hi, fa, fb, rs, bd, id2, td);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (done) ok = 1; else wait_done(req, ok);
      if (ok) begin
         check({req, " freq"}, longint'(freq_hz), f);
         check({req, " err"}, longint'(err), longint'(e));
         held = freq_hz;
         @(negedge clk);
         check("R9 done single cycle", longint'(done), 0);
         repeat (4) @(negedge clk);
         check("R9 freq held", longint'(freq_hz), longint'(held));
      end
   endtask

   task automatic t_reset();
      check("R1 done at reset", longint'(done), 0);
      check("R1 freq at reset", longint'(freq_hz), 0);
      check("R1 err at reset", longint'(err), 0);
   endtask

   task automatic t_ids();
      run("R2 off", 3'd0, 1, 6'd27, 6'd27, 2'd0, 3'd0, 2'd0, 6'd0);
      run("R2 slow", 3'd3, 1, 6'd27, 6'd27, 2'd0, 3'd0, 2'd0, 6'd0);
      run("R2 xtal", 3'd4, 0, 6'd0, 6'd0, 2'd1, 3'd0, 2'd0, 6'd0);
      run("R2 xtal/8", 3'd5, 0, 6'd0, 6'd0, 2'd3, 3'd0, 2'd0, 6'd0);
      run("R2 unsupported 6", 3'd6, 1, 6'd0, 6'd0, 2'd1, 3'd0, 2'd0, 6'd0);
      run("R2 unsupported 7", 3'd7, 1, 6'd27, 6'd27, 2'd0, 3'd0, 2'd0, 6'd0);
   endtask

   task automatic t_pll();
      run("R3 pll x22", 3'd1, 1, 6'd0, 6'd0, 2'd0, 3'd0, 2'd0, 6'd0);
      run("R3 pll x20", 3'd1, 0, 6'd0, 6'd0, 2'd0, 3'd0, 2'd0, 6'd0);
   endtask

   task automatic t_frac();
      run("R4 root1 fracB", 3'd1, 1, 6'd16, 6'd27, 2'd1, 3'd0, 2'd0, 6'd0);
      run("R4 root2 fracA", 3'd1, 1, 6'd16, 6'd27, 2'd2, 3'd0, 2'd0, 6'd0);
      run("R4 root1 floor", 3'd1, 0, 6'd5, 6'd35, 2'd1, 3'd0, 2'd0, 6'd0);
      run("R4 root2 max frac", 3'd1, 0, 6'd63, 6'd1, 2'd2, 3'd0, 2'd0, 6'd0);
   endtask

   task automatic t_half();
      run("R5 root3 half", 3'd1, 1, 6'd9, 6'd27, 2'd3, 3'd0, 2'd0, 6'd0);
      run("R5 root3 odd", 3'd1, 1, 6'd9, 6'd35, 2'd3, 3'd0, 2'd0, 6'd0);
   endtask

   task automatic t_chain();
      run("R6 bus4 ipg2", 3'd1, 1, 6'd0, 6'd0, 2'd0, 3'd3, 2'd1, 6'd0);
      run("R6 bus3 ipg4", 3'd1, 1, 6'd0, 6'd0, 2'd0, 3'd2, 2'd3, 6'd0);
      run("R6 bus8 ipg3 frac", 3'd1, 0, 6'd0, 6'd35, 2'd1, 3'd7, 2'd2, 6'd0);
   endtask

   task automatic t_timer();
      run("R7 timer /6", 3'd2, 1, 6'd0, 6'd0, 2'd0, 3'd3, 2'd1, 6'd5);
      run("R7 timer /64", 3'd2, 0, 6'd0, 6'd19, 2'd3, 3'd1, 2'd0, 6'd63);
      run("R7 ipg ignores tmr", 3'd1, 1, 6'd0, 6'd0, 2'd0, 3'd3, 2'd1, 6'd63);
   endtask

   task automatic t_zero();
      run("R8 root1 zero", 3'd1, 1, 6'd16, 6'd0, 2'd1, 3'd0, 2'd0, 6'd0);
      run("R8 root2 zero", 3'd2, 1, 6'd0, 6'd16, 2'd2, 3'd0, 2'd0, 6'd0);
      run("R8 root3 zero", 3'd1, 0, 6'd16, 6'd0, 2'd3, 3'd1, 2'd1, 6'd0);
      run("R8 unselected zero", 3'd1, 1, 6'd0, 6'd27, 2'd1, 3'd1, 2'd0, 6'd0);
      run("R8 root0 zeros", 3'd1, 0, 6'd0, 6'd0, 2'd0, 3'd1, 2'd0, 6'd0);
   endtask

   task automatic t_busy();
      longint f; bit e; bit ok; int extra;
      model(3'd2, 1, 6'd0, 6'd27, 2'd1, 3'd1, 2'd1, 6'd2, f, e);
      @(negedge clk);
      drive(3'd2, 1, 6'd0, 6'd27, 2'd1, 3'd1, 2'd1, 6'd2);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      drive(3'd4, 0, 6'd5, 6'd0, 2'd2, 3'd7, 2'd3, 6'd9);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done("R10", ok);
      if (ok) begin
         check("R10 busy start ignored freq", longint'(freq_hz), f);
         check("R10 busy start ignored err", longint'(err), longint'(e));
      end
      extra = 0;
      for (int i = 0; i < 600; i++) begin
         @(negedge clk);
         if (done) extra++;
      end
      check("R10 no second done", longint'(extra), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ids();
      t_pll();
      t_frac();
      t_half();
      t_chain();
      t_timer();
      t_zero();
      t_busy();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule